// File: doc/BRIEF.md
# Trace Event Sequencer Bank

This block holds eight programmable sequencers that watch a 16-bit event vector. Each sequencer walks through up to four chosen events in order. When it reaches the end of its chain, it raises the action flags it has been given for one cycle. The actions from all sequencers are then merged into one trace command and one clear-usage request. Two further signals leave the block: a timed, active-low debug pin pulse and a debug interrupt that stays set until it is cleared by a read.

Each sequencer is programmed with a 16-bit select word and a 6-bit action word. A select value of all ones means "ignore". Placing it in the trailing positions shortens the chain. Placing it in the first position makes the sequencer fire on every cycle, which is useful for capturing all bus activity. The surrounding trace logic supplies the events and the read strobe, and it consumes the command outputs.

Top module: `trace_seq_bank`

## Requirements
- R1: While reset is high and after it is released, the outputs are idle: `trc_cmd_o`=0, `clr_use_o`=0, `dbg_pin_n_o`=1, `dbg_irq_o`=0.
- R2: In sequencer n's select word, the first event select is in bits 15:12, the second in 11:8, the third in 7:4 and the fourth in 3:0. The sequencer moves forward one stage per cycle in which the event bit named by its current select is high. Events that do not match leave it where it is. Its actions appear on the outputs in the cycle after the clock edge that samples the final matching event.
- R3: Select value 4'hF in the trailing positions shortens the chain, so the sequence completes on the last select that is not 4'hF.
- R4: When the first select is 4'hF, the sequencer completes on every cycle, whatever the events are.
- R5: The eight sequencers keep separate progress, so one event can advance one sequencer while it completes another.
- R6: Action bits are bit0 start, bit1 stop, bit2 freeze, bit3 clear usage, bit4 debug pin, bit5 debug interrupt. `trc_cmd_o` is encoded 0 none, 1 start, 2 stop, 3 freeze. When several sequencers complete at once, freeze wins over stop, and stop wins over start.
- R7: `clr_use_o` is the OR of the clear-usage bits of all sequencers that complete in the same cycle.
- R8: After completing, a sequencer returns to its first stage. Its actions last one cycle, and firing again needs the whole chain again.
- R9: A debug-pin action drives `dbg_pin_n_o` low for exactly 10 cycles, starting in the cycle after the completing edge.
- R10: A debug-pin action that arrives while a pulse is running restarts the 10-cycle count.
- R11: A debug-interrupt action sets `dbg_irq_o`, which stays set until a cycle with `cfg_rd_i` high clears it. If a set and a read fall in the same cycle, the set wins.
- R12: The debug pin and the interrupt are raised even when no trace command bit is set, and `trc_cmd_o` stays 0 in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_sel_i | input | 128 | Select words; sequencer n uses bits [16n+15:16n] |
| seq_act_i | input | 48 | Action words; sequencer n uses bits [6n+5:6n] |
| evt_i | input | 16 | Event vector, indexed by select value |
| cfg_rd_i | input | 1 | Configuration read strobe, clears the interrupt |
| trc_cmd_o | output | 2 | Merged trace command |
| clr_use_o | output | 1 | Merged clear-usage request |
| dbg_pin_n_o | output | 1 | Active-low debug pin |
| dbg_irq_o | output | 1 | Debug interrupt |

## Verification
The bench builds the block with its default parameters: eight sequencers, four stages, 4-bit selects and a 10-cycle pulse. With these values every action bit, every priority pair and a full four-event chain can be exercised. The 10-cycle length also leaves room to restart a pulse part-way through and to observe the exact edge where the pin returns high.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_START  = 2'd1,
    CMD_STOP   = 2'd2,
    CMD_FREEZE = 2'd3
  } trc_cmd_e;

  // bit0 start ... bit5 debug interrupt
  typedef struct packed {
    logic dbg_cpu;
    logic dbg_pin;
    logic clr_use;
    logic freeze;
    logic stop;
    logic start;
  } act_t;

  localparam int ACT_W = $bits(act_t);

endpackage

// File: rtl/trace_seq_unit.sv
module trace_seq_unit #(
  parameter int SEL_W  = 4,
  parameter int STAGES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [STAGES*SEL_W-1:0]   sel_i,
  input  logic [(1<<SEL_W)-1:0]     evt_i,
  output logic                      done_o
);
  localparam int STG_W = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam logic [SEL_W-1:0] IGN = '1;

  logic [SEL_W-1:0] sel_f [STAGES];
  logic [STAGES-1:0] tail_ign;
  logic [STG_W-1:0] stage_q;
  logic [SEL_W-1:0] cur_sel;
  logic first_ign, hit;

  // first event sits in the most significant field
  for (genvar k = 0; k < STAGES; k++) begin : g_field
    assign sel_f[k] = sel_i[(STAGES-1-k)*SEL_W +: SEL_W];
    if (k < STAGES-1) begin : g_mid
      assign tail_ign[k] = (sel_i[(STAGES-2-k)*SEL_W +: SEL_W] == IGN);
    end else begin : g_last
      assign tail_ign[k] = 1'b1;
    end
  end

  always_comb begin
    cur_sel   = sel_f[stage_q];
    first_ign = (sel_f[0] == IGN);
    hit       = first_ign | ((cur_sel != IGN) & evt_i[cur_sel]);
    done_o    = hit & (first_ign | tail_ign[stage_q]);
  end

  always_ff @(posedge clk) begin
    if (rst)         stage_q <= '0;
    else if (done_o) stage_q <= '0;
    else if (hit)    stage_q <= stage_q + 1'b1;
  end

  AST_RESTART_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (stage_q == '0)); // R8
  AST_WAIT_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(stage_q)); // R2
endmodule

// File: rtl/trace_seq_merge.sv
module trace_seq_merge
  import trace_seq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N*ACT_W-1:0] act_i,
  input  logic [N-1:0]     done_i,
  output trc_cmd_e         cmd_o,
  output logic             clr_o,
  output logic             pin_req_o,
  output logic             irq_req_o
);
  logic any_start, any_stop, any_frz, any_clr;
  trc_cmd_e cmd_d;

  always_comb begin
    act_t a;
    any_start = 1'b0; any_stop = 1'b0; any_frz = 1'b0; any_clr = 1'b0;
    pin_req_o = 1'b0; irq_req_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      a = act_t'(act_i[i*ACT_W +: ACT_W]);
      if (done_i[i]) begin
        any_start |= a.start;
        any_stop  |= a.stop;
        any_frz   |= a.freeze;
        any_clr   |= a.clr_use;
        pin_req_o |= a.dbg_pin;
        irq_req_o |= a.dbg_cpu;
      end
    end
    if (any_frz)        cmd_d = CMD_FREEZE;
    else if (any_stop)  cmd_d = CMD_STOP;
    else if (any_start) cmd_d = CMD_START;
    else                cmd_d = CMD_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o <= CMD_NONE;
      clr_o <= 1'b0;
    end else begin
      cmd_o <= cmd_d;
      clr_o <= any_clr;
    end
  end

  AST_FREEZE_WINS: assert property (@(posedge clk) disable iff (rst)
    any_frz |=> (cmd_o == CMD_FREEZE)); // R6
  AST_STOP_OVER_START: assert property (@(posedge clk) disable iff (rst)
    (any_stop && !any_frz) |=> (cmd_o == CMD_STOP)); // R6
  AST_CLEAR_MERGED: assert property (@(posedge clk) disable iff (rst)
    any_clr |=> clr_o); // R7
endmodule

// File: rtl/trace_seq_signal.sv
module trace_seq_signal #(
  parameter int PULSE_LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_req_i,
  input  logic irq_req_i,
  input  logic rd_i,
  output logic pin_n_o,
  output logic irq_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (pin_req_i)        cnt_d = LOAD;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pin_n_o <= 1'b1;
      irq_o   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pin_n_o <= (cnt_d == '0);
      if (irq_req_i)  irq_o <= 1'b1;
      else if (rd_i)  irq_o <= 1'b0;
    end
  end

  // checker: length of the current low run on the pin
  logic [CNT_W:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || pin_req_i) low_run <= '0;
    else if (!pin_n_o)    low_run <= low_run + 1'b1;
    else                  low_run <= '0;
  end

  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (low_run == (CNT_W+1)'(PULSE_LEN)) |-> pin_n_o); // R9
  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
    pin_req_i |=> !pin_n_o); // R12
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !rd_i) |=> irq_o); // R11
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    irq_req_i |=> irq_o); // R11
endmodule

// File: rtl/trace_seq_bank.sv
module trace_seq_bank
  import trace_seq_pkg::*;
#(
  parameter int NUM_SEQ   = 8,
  parameter int SEL_W     = 4,
  parameter int STAGES    = 4,
  parameter int PULSE_LEN = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SEQ*STAGES*SEL_W-1:0] seq_sel_i,
  input  logic [NUM_SEQ*ACT_W-1:0]    seq_act_i,
  input  logic [(1<<SEL_W)-1:0]       evt_i,
  input  logic                        cfg_rd_i,
  output logic [1:0]                  trc_cmd_o,
  output logic                        clr_use_o,
  output logic                        dbg_pin_n_o,
  output logic                        dbg_irq_o
);
  localparam int WORD_W = STAGES * SEL_W;

  logic [NUM_SEQ-1:0] done;
  trc_cmd_e cmd;
  logic pin_req, irq_req;

  for (genvar n = 0; n < NUM_SEQ; n++) begin : g_seq
    trace_seq_unit #(.SEL_W(SEL_W), .STAGES(STAGES)) u_unit (
      .clk    (clk),
      .rst    (rst),
      .sel_i  (seq_sel_i[n*WORD_W +: WORD_W]),
      .evt_i  (evt_i),
      .done_o (done[n])
    );
  end

  trace_seq_merge #(.N(NUM_SEQ)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .act_i     (seq_act_i),
    .done_i    (done),
    .cmd_o     (cmd),
    .clr_o     (clr_use_o),
    .pin_req_o (pin_req),
    .irq_req_o (irq_req)
  );

  trace_seq_signal #(.PULSE_LEN(PULSE_LEN)) u_signal (
    .clk       (clk),
    .rst       (rst),
    .pin_req_i (pin_req),
    .irq_req_i (irq_req),
    .rd_i      (cfg_rd_i),
    .pin_n_o   (dbg_pin_n_o),
    .irq_o     (dbg_irq_o)
  );

  assign trc_cmd_o = cmd;

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (trc_cmd_o == 2'd0 && !clr_use_o && dbg_pin_n_o && !dbg_irq_o)); // R1
endmodule

// File: tb/trace_seq_bank_tb.sv
module trace_seq_bank_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [127:0] seq_sel;
  logic [47:0]  seq_act;
  logic [15:0]  evt = '0;
  logic cfg_rd = 1'b0;
  logic [1:0] trc_cmd;
  logic clr_use, pin_n, irq;

  logic [15:0] sel_w [8];
  logic [5:0]  act_w [8];

  localparam logic [5:0] A_START = 6'b000001, A_STOP = 6'b000010,
                         A_FRZ = 6'b000100, A_CLR = 6'b001000,
                         A_PIN = 6'b010000, A_CPU = 6'b100000;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      seq_sel[i*16 +: 16] = sel_w[i];
      seq_act[i*6 +: 6]   = act_w[i];
    end
  end

  trace_seq_bank u_dut (
    .clk(clk), .rst(rst), .seq_sel_i(seq_sel), .seq_act_i(seq_act),
    .evt_i(evt), .cfg_rd_i(cfg_rd), .trc_cmd_o(trc_cmd),
    .clr_use_o(clr_use), .dbg_pin_n_o(pin_n), .dbg_irq_o(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < 8; i++) begin
      sel_w[i] = 16'h0000;
      act_w[i] = 6'b0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; evt = '0; cfg_rd = 1'b0;
    repeat (2) tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic fire(int ev);
    evt = 16'(1) << ev;
    tick();
    evt = '0;
  endtask

  task automatic t_reset();
    clear_cfg();
    rst = 1'b1;
    repeat (2) tick();
    chk("R1 cmd in reset", trc_cmd, 0);
    chk("R1 pin in reset", pin_n, 1);
    rst = 1'b0;
    tick();
    chk("R1 cmd", trc_cmd, 0);
    chk("R1 clr", clr_use, 0);
    chk("R1 pin", pin_n, 1);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_full_chain();
    clear_cfg();
    sel_w[0] = 16'h1234; act_w[0] = A_START;
    do_reset();
    fire(1); chk("R2 after ev1", trc_cmd, 0);
    fire(2); chk("R2 after ev2", trc_cmd, 0);
    fire(9); chk("R2 non-match", trc_cmd, 0);
    fire(4); chk("R2 out of order", trc_cmd, 0);
    fire(3); chk("R2 after ev3", trc_cmd, 0);
    fire(4); chk("R2 complete start", trc_cmd, 1);
    tick();  chk("R8 one cycle", trc_cmd, 0);
    fire(4); chk("R8 restart needed", trc_cmd, 0);
  endtask

  task automatic t_short();
    clear_cfg();
    sel_w[0] = 16'h67FF; act_w[0] = A_STOP;
    do_reset();
    fire(6); chk("R3 first of two", trc_cmd, 0);
    fire(7); chk("R3 short complete", trc_cmd, 2);
    tick();  chk("R3 idle after", trc_cmd, 0);
  endtask

  task automatic t_always();
    clear_cfg();
    sel_w[0] = 16'hFFFF; act_w[0] = A_START;
    do_reset();
    evt = '0;
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R4 every cycle", trc_cmd, 1);
    end
  endtask

  task automatic t_prio();
    clear_cfg();
    sel_w[0] = 16'h2FFF; act_w[0] = A_START;
    sel_w[1] = 16'h2FFF; act_w[1] = A_STOP;
    sel_w[2] = 16'h3FFF; act_w[2] = A_FRZ;
    sel_w[3] = 16'hDFFF; act_w[3] = A_START;
    do_reset();
    fire(13); chk("R6 start alone", trc_cmd, 1);
    fire(2);  chk("R6 stop over start", trc_cmd, 2);
    evt = 16'h000C; tick(); evt = '0;
    chk("R6 freeze over all", trc_cmd, 3);
  endtask

  task automatic t_independent();
    clear_cfg();
    sel_w[0] = 16'h89FF; act_w[0] = A_START;
    sel_w[5] = 16'h98FF; act_w[5] = A_STOP;
    do_reset();
    fire(8); chk("R5 no completion", trc_cmd, 0);
    fire(9); chk("R5 seq0 completes", trc_cmd, 1);
    fire(8); chk("R5 seq5 completes", trc_cmd, 2);
  endtask

  task automatic t_clear();
    clear_cfg();
    sel_w[1] = 16'hAFFF; act_w[1] = A_CLR;
    sel_w[6] = 16'hBFFF; act_w[6] = A_CLR;
    do_reset();
    fire(10); chk("R7 clr seq1", clr_use, 1);
    chk("R7 no cmd", trc_cmd, 0);
    tick();   chk("R7 clr drops", clr_use, 0);
    fire(11); chk("R7 clr seq6", clr_use, 1);
  endtask

  task automatic t_pin();
    clear_cfg();
    sel_w[2] = 16'h0FFF; act_w[2] = A_PIN;
    do_reset();
    fire(0);
    chk("R9 pin low start", pin_n, 0);
    chk("R12 no cmd with pin", trc_cmd, 0);
    for (int i = 1; i < 10; i++) begin
      tick(); chk("R9 pin held low", pin_n, 0);
    end
    tick(); chk("R9 pin released", pin_n, 1);
  endtask

  task automatic t_retrigger();
    clear_cfg();
    sel_w[2] = 16'h0FFF; act_w[2] = A_PIN;
    do_reset();
    fire(0);
    repeat (4) tick();
    fire(0); chk("R10 low on restart", pin_n, 0);
    for (int i = 1; i < 10; i++) begin
      tick(); chk("R10 low after restart", pin_n, 0);
    end
    tick(); chk("R10 released after restart", pin_n, 1);
  endtask

  task automatic t_irq();
    clear_cfg();
    sel_w[3] = 16'h5FFF; act_w[3] = A_CPU;
    do_reset();
    fire(5);
    chk("R11 irq set", irq, 1);
    chk("R12 no cmd with irq", trc_cmd, 0);
    chk("R12 pin untouched", pin_n, 1);
    repeat (3) tick();
    chk("R11 irq held", irq, 1);
    cfg_rd = 1'b1; tick(); cfg_rd = 1'b0;
    chk("R11 irq cleared by read", irq, 0);
    tick(); chk("R11 irq stays clear", irq, 0);
    evt = 16'h0020; cfg_rd = 1'b1; tick(); evt = '0; cfg_rd = 1'b0;
    chk("R11 set beats read", irq, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_cfg();
    t_reset();
    t_full_chain();
    t_short();
    t_always();
    t_prio();
    t_independent();
    t_clear();
    t_pin();
    t_retrigger();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule